// File: doc/BRIEF.md
# 5b6b Code Word Decoder

This block takes one 6-bit line code word per cycle and returns the 5-bit data value it carries. Balanced words (three ones) hold the data in bits 5:1, and bit 0 is the balancing bit that the encoder appended. The decoder drops bit 0 to recover the data. Unbalanced words hold one of twelve data values that have an odd weight far from the middle. These words come in complementary pairs. The decoder matches the received word, or its complement, against a stored pair table.

The decoder also tracks running disparity. The encoder always sends the pair member that steers disparity back toward zero, so correct traffic alternates positive and negative unbalanced words, starting with a positive one. A word with the wrong polarity raises a disparity error. A word that no rule could produce raises a code error. Results appear one clock after the word is presented, together with a valid strobe.

Top module: `code_word_decoder`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, out_valid, out_data, code_err and disp_err are all zero. Running disparity restarts at zero, so a reset received between words discards any disparity built up before it.
- R2: out_valid is high exactly one cycle after in_valid was high. When out_valid is low, out_data, code_err and disp_err are zero.
- R3: A word of weight 3 decodes to out_data = in_word[5:1] with neither flag set, and it leaves running disparity unchanged.
- R4: A word of weight 0, 1, 5 or 6 raises code_err. It gives out_data = 0, does not raise disp_err and leaves running disparity unchanged.
- R5: A weight-4 word from this positive-form table decodes to the listed data: 010111→00000, 100111→00001, 011011→00010, 101011→00100, 110011→01000, 011101→10000, 110110→11110, 101110→11101, 111001→11011, 110101→10111, 101101→01111, 111010→11111. A weight-2 word whose bitwise complement appears in this table decodes to the same data.
- R6: The weight-4 words 111100, 011110 and 001111, and their weight-2 complements, raise code_err. They give out_data = 0 and leave running disparity unchanged.
- R7: Running disparity takes one of three values: -2, 0 or +2. A valid weight-4 word adds 2 to it and a valid weight-2 word subtracts 2, with the result clamped to the range -2..+2. Balanced words and code-error words do not change it.
- R8: disp_err is raised for a valid weight-2 word received at disparity 0 or -2, and for a valid weight-4 word received at +2. The data is still decoded, and disparity is still updated as in R7 so that decoding resynchronises.
- R9: Cycles with in_valid low leave running disparity unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_word holds a code word this cycle |
| in_word | input | 6 | Received 6-bit code word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 5 | Decoded data value |
| code_err | output | 1 | Word violates the code rules |
| disp_err | output | 1 | Unbalanced word has the wrong polarity for the current disparity |

## Verification
Running disparity cannot be seen at the ports. The hardest cases to reach are therefore the disparity -2 state and the over-limit clamp, because correct traffic never leaves 0 and +2. The bench keeps its own disparity value. Before each code word it sends steering words to reach a chosen state, deliberately sending a negative word at zero to enter -2. It then sweeps all 64 code words from each of the three states. The disparity left behind by every word shows up in the disp_err result of the steering and swept words that follow, and idle cycles and a mid-stream reset are checked the same way.

// File: rtl/code_word_decoder.sv
module code_word_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [5:0] in_word,
  output logic       out_valid,
  output logic [4:0] out_data,
  output logic       code_err,
  output logic       disp_err
);

  localparam logic [1:0] RD_ZERO = 2'b00;
  localparam logic [1:0] RD_POS  = 2'b01;
  localparam logic [1:0] RD_NEG  = 2'b10;

  logic [1:0] rd_q, rd_d;
  logic [2:0] weight;
  logic       balanced, heavy, light, pair_hit, pair_ok, word_bad, polarity_bad;
  logic [5:0] pos_form;
  logic [4:0] pair_data, data_d;

  always_comb begin
    weight = 3'd0;
    for (int i = 0; i < 6; i++) weight = weight + {2'b00, in_word[i]};
  end

  assign balanced = (weight == 3'd3);
  assign heavy    = (weight == 3'd4);
  assign light    = (weight == 3'd2);
  assign pos_form = heavy ? in_word : ~in_word;

  always_comb begin
    pair_hit  = 1'b1;
    pair_data = 5'b00000;
    case (pos_form)
      6'b010111: pair_data = 5'b00000;
      6'b100111: pair_data = 5'b00001;
      6'b011011: pair_data = 5'b00010;
      6'b101011: pair_data = 5'b00100;
      6'b110011: pair_data = 5'b01000;
      6'b011101: pair_data = 5'b10000;
      6'b110110: pair_data = 5'b11110;
      6'b101110: pair_data = 5'b11101;
      6'b111001: pair_data = 5'b11011;
      6'b110101: pair_data = 5'b10111;
      6'b101101: pair_data = 5'b01111;
      6'b111010: pair_data = 5'b11111;
      default:   pair_hit  = 1'b0;
    endcase
  end

  assign pair_ok  = (heavy | light) & pair_hit;
  assign word_bad = ~balanced & ~pair_ok;
  assign data_d   = balanced ? in_word[5:1] : (pair_ok ? pair_data : 5'b00000);

  assign polarity_bad = pair_ok & ((heavy & (rd_q == RD_POS)) | (light & (rd_q != RD_POS)));

  always_comb begin
    rd_d = rd_q;
    if (in_valid && pair_ok) begin
      if (heavy) rd_d = (rd_q == RD_NEG) ? RD_ZERO : RD_POS;
      else       rd_d = (rd_q == RD_POS) ? RD_ZERO : RD_NEG;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= RD_ZERO;
      out_valid <= 1'b0;
      out_data  <= 5'b00000;
      code_err  <= 1'b0;
      disp_err  <= 1'b0;
    end else begin
      rd_q      <= rd_d;
      out_valid <= in_valid;
      out_data  <= in_valid ? data_d : 5'b00000;
      code_err  <= in_valid & word_bad;
      disp_err  <= in_valid & polarity_bad;
    end
  end

endmodule

// File: rtl/code_word_decoder_chk.sv
module code_word_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [5:0] in_word,
  input logic       out_valid,
  input logic [4:0] out_data,
  input logic       code_err,
  input logic       disp_err
);

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (out_data == 5'b0 && !code_err && !disp_err)); // R2
  AST_BALANCED_STRIP: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && $countones(in_word) == 3) |=> (out_data == $past(in_word[5:1]) && !code_err && !disp_err)); // R3
  AST_BAD_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && ($countones(in_word) <= 1 || $countones(in_word) >= 5)) |=> (code_err && !disp_err && out_data == 5'b0)); // R4
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) code_err |-> !disp_err); // R8

endmodule

bind code_word_decoder code_word_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_data(out_data), .code_err(code_err), .disp_err(disp_err)
);

// File: tb/code_word_decoder_bench.sv
module code_word_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [5:0] in_word = 6'b0;
  logic       out_valid;
  logic [4:0] out_data;
  logic       code_err;
  logic       disp_err;

  int checks = 0;
  int fails = 0;
  int mrd = 0;

  always #4 clk = ~clk;

  code_word_decoder u_code_word_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_data(out_data), .code_err(code_err), .disp_err(disp_err)
  );

  function automatic int ones6(input logic [5:0] w);
    int n = 0;
    for (int i = 0; i < 6; i++) n += int'(w[i]);
    return n;
  endfunction

  function automatic logic [5:0] enc_pos(input logic [4:0] d);
    case (d)
      5'b00000: return 6'b010111;
      5'b00001: return 6'b100111;
      5'b00010: return 6'b011011;
      5'b00100: return 6'b101011;
      5'b01000: return 6'b110011;
      5'b10000: return 6'b011101;
      5'b11110: return 6'b110110;
      5'b11101: return 6'b101110;
      5'b11011: return 6'b111001;
      5'b10111: return 6'b110101;
      5'b01111: return 6'b101101;
      5'b11111: return 6'b111010;
      default:  return 6'b000000;
    endcase
  endfunction

  task automatic check(input string req, input logic ov, input logic [4:0] od,
                       input logic ce, input logic de);
    checks++;
    if (out_valid !== ov || out_data !== od || code_err !== ce || disp_err !== de) begin
      fails++;
      $display("FAIL %s: got v=%b d=%b ce=%b de=%b, expected v=%b d=%b ce=%b de=%b",
               req, out_valid, out_data, code_err, disp_err, ov, od, ce, de);
    end
  endtask

  task automatic send(input logic v, input logic [5:0] w);
    int n;
    logic hit, pos;
    logic [4:0] ed;
    logic ece, ede;
    string req;
    in_valid = v;
    in_word = w;
    n = ones6(w);
    hit = 1'b0; pos = 1'b0; ed = 5'b0; ece = 1'b0; ede = 1'b0;
    if (!v) req = "R9";
    else if (n == 3) begin req = "R3"; ed = w[5:1]; end
    else if (n == 2 || n == 4) begin
      for (int d = 0; d < 32; d++) begin
        if (enc_pos(5'(d)) != 6'b0 && (enc_pos(5'(d)) == w || ~enc_pos(5'(d)) == w)) begin
          hit = 1'b1; ed = 5'(d); pos = (n == 4);
        end
      end
      if (!hit) begin req = "R6"; ece = 1'b1; end
      else begin
        ede = pos ? (mrd == 2) : (mrd != 2);
        req = ede ? "R8" : "R5/R7";
        mrd = pos ? ((mrd + 2 > 2) ? 2 : mrd + 2) : ((mrd - 2 < -2) ? -2 : mrd - 2);
      end
    end else begin req = "R4"; ece = 1'b1; end
    @(negedge clk);
    check(req, v, ed, ece, ede);
  endtask

  task automatic steer(input int target);
    while (mrd != target) send(1'b1, (mrd < target) ? 6'b010111 : 6'b101000);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", 1'b0, 5'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, 5'b0, 1'b0, 1'b0);
    for (int pass = 0; pass < 3; pass++) begin
      int tgt = (pass == 0) ? 0 : ((pass == 1) ? 2 : -2);
      for (int c = 0; c < 64; c++) begin
        steer(tgt);
        send(1'b1, 6'(c));
        if (pass == 1 && c[0]) send(1'b0, 6'(63 - c));
      end
    end
    steer(2);
    rst_n = 1'b0;
    in_valid = 1'b0;
    #1;
    check("R1", 1'b0, 5'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    mrd = 0;
    send(1'b1, 6'b101000);
    send(1'b1, 6'b010111);
    send(1'b1, 6'b010111);
    send(1'b0, 6'b000000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule